// File: doc/BRIEF.md
# Windowed Complex Power Meter

The block estimates the mean power of a stream of complex baseband samples. A measurement window begins a programmable number of samples after a sync pulse. During the window the block sums the squared magnitude of each sample. When the window closes, the sums are copied into result registers that a host can read, and a sticky interrupt flag is raised.

The block has two modes. In diversity mode, every valid input cycle carries two I/Q pairs: a signal pair and a diversity pair. Their powers are summed into two separate accumulators. In single-path mode only the signal pair is used, and the diversity result reads as zero.

A restart timer, counted in blocks of 1024 samples, can reopen the window periodically. This timer runs independently of the window length. A host write of the acknowledge input clears the interrupt and allows the next completion to overwrite the results.

Top module: `pm_power_meter`

## Requirements
- R1: A window spans exactly `cfg_win_len` × 4 valid samples. On the clock edge that takes the last of them, the sums appear on the result ports and `irq` goes high. Cycles with `in_valid` low are not counted.
- R2: With `cfg_diversity` = 1, `pwr_sig` equals the sum of sig_i² + sig_q² and `pwr_div` equals the sum of div_i² + div_q² over the window. The inputs are signed two's complement. Full-scale values (−32768) neither wrap nor saturate.
- R3: With `cfg_diversity` = 0, `pwr_sig` equals the sum of sig_i² + sig_q². The diversity inputs have no effect, and `pwr_div` is latched as 0.
- R4: A sample on the same cycle as `sync_pulse` is not counted. The next `cfg_start_dly` valid samples are skipped, and the one after them is the first sample of the window.
- R5: When `cfg_restart_ivl` ≠ 0, a new window with cleared sums begins after every `cfg_restart_ivl` × 1024 valid samples counted from the first window sample. When it is 0, no periodic restart occurs.
- R6: `irq` stays high until a cycle with `irq_ack` high. A completion while `irq` is high and `irq_ack` is low leaves the result ports unchanged. A completion on an `irq_ack` cycle latches the new results and keeps `irq` high.
- R7: A `sync_pulse` during a delay, window or wait period discards the partial sums and restarts the delay, the window and the restart timer.
- R8: While `cfg_win_len` = 0, a sync pulse starts no measurement and `irq` is never raised.
- R9: After reset, `irq` is 0 and both result ports are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_diversity | input | 1 | 1 selects diversity mode (two pairs), 0 selects single-path mode |
| cfg_win_len | input | 16 | Window length in groups of four samples; 0 disables measurement |
| cfg_start_dly | input | 8 | Valid samples skipped after a sync pulse |
| cfg_restart_ivl | input | 8 | Restart period in units of 1024 samples; 0 disables restart |
| sync_pulse | input | 1 | Selected sync event, one cycle wide |
| in_valid | input | 1 | Input sample qualifier |
| sig_i | input | 16 | Signal path in-phase sample, signed |
| sig_q | input | 16 | Signal path quadrature sample, signed |
| div_i | input | 16 | Diversity path in-phase sample, signed |
| div_q | input | 16 | Diversity path quadrature sample, signed |
| irq_ack | input | 1 | Host write that clears the interrupt flag |
| pwr_sig | output | 52 | Latched signal-path power sum |
| pwr_div | output | 52 | Latched diversity-path power sum |
| irq | output | 1 | Sticky completion interrupt |

## Verification
Every result in this block is due one clock edge after the input that causes it. The last sample of a window, presented at edge n, shows up on `pwr_sig`, `pwr_div` and `irq` right after edge n. An `irq_ack` at edge n drops `irq` after the same edge. The bench keeps a behavioural model that applies each edge's inputs at that edge, tracking the sample index since the start and using modulo arithmetic for windows and restarts. Inputs are driven on falling edges, and all three outputs are compared with the model on every falling edge. Each comparison is tagged with the requirement that the current stimulus phase targets.

// File: rtl/pm_pkg.sv
package pm_pkg;
   typedef enum logic [1:0] {
      PM_IDLE  = 2'd0,
      PM_DELAY = 2'd1,
      PM_RUN   = 2'd2,
      PM_WAIT  = 2'd3
   } pm_state_e;

   localparam int PM_NPATH = 2;
endpackage

// File: rtl/pm_square.sv
module pm_square #(
   parameter int SMP_W = 16,
   parameter int PWR_W = 2*SMP_W + 1
) (
   input  logic signed [SMP_W-1:0] in_i,
   input  logic signed [SMP_W-1:0] in_q,
   output logic        [PWR_W-1:0] mag2
);
   logic signed [2*SMP_W-1:0] sq_i;
   logic signed [2*SMP_W-1:0] sq_q;

   if (PWR_W < 2*SMP_W + 1) begin : g_chk_w
      $error("pm_square: PWR_W too narrow for a sum of two squares");
   end

   always_comb begin
      sq_i = in_i * in_i;
      sq_q = in_q * in_q;
      mag2 = PWR_W'($unsigned(sq_i)) + PWR_W'($unsigned(sq_q));
   end
endmodule

// File: rtl/pm_accum.sv
module pm_accum #(
   parameter int PWR_W = 33,
   parameter int ACC_W = 52
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic [PWR_W-1:0] mag2,
   output logic [ACC_W-1:0] sum
);
   logic [ACC_W-1:0] acc_q;

   always_comb sum = acc_q + (en ? ACC_W'(mag2) : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (clr) acc_q <= '0;
      else if (en)  acc_q <= sum;
   end

   // R2: adding a sample never wraps the running sum
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (sum >= acc_q));

   // R3: a path that is not enabled keeps its running sum
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(acc_q));
endmodule

// File: rtl/pm_window_ctrl.sv
module pm_window_ctrl
   import pm_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int DLY_W     = 8,
   parameter int IVL_W     = 8,
   parameter int GRP_SHIFT = 2,
   parameter int IVL_SHIFT = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] cfg_win_len,
   input  logic [DLY_W-1:0] cfg_start_dly,
   input  logic [IVL_W-1:0] cfg_restart_ivl,
   input  logic             sync_pulse,
   input  logic             in_valid,
   output logic             acc_en,
   output logic             acc_clr,
   output logic             win_last
);
   localparam int SCNT_W = LEN_W + GRP_SHIFT;
   localparam int ICNT_W = IVL_W + IVL_SHIFT;

   pm_state_e         state_q;
   logic [DLY_W-1:0]  dcnt_q;
   logic [SCNT_W-1:0] scnt_q;
   logic [ICNT_W-1:0] icnt_q;
   logic [SCNT_W-1:0] win_samples;
   logic [ICNT_W-1:0] ivl_samples;
   logic              ivl_tick;
   logic              ivl_wrap;

   always_comb begin
      win_samples = SCNT_W'(cfg_win_len) << GRP_SHIFT;
      ivl_samples = ICNT_W'(cfg_restart_ivl) << IVL_SHIFT;
      acc_en   = (state_q == PM_RUN) && in_valid && !sync_pulse;
      win_last = acc_en && (cfg_win_len != '0)
                 && ((scnt_q + SCNT_W'(1)) == win_samples);
      ivl_tick = ((state_q == PM_RUN) || (state_q == PM_WAIT)) && in_valid
                 && !sync_pulse && (cfg_restart_ivl != '0);
      ivl_wrap = ivl_tick && ((icnt_q + ICNT_W'(1)) == ivl_samples);
      acc_clr  = sync_pulse || ivl_wrap || win_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PM_IDLE;
         dcnt_q  <= '0;
         scnt_q  <= '0;
         icnt_q  <= '0;
      end else if (sync_pulse) begin
         dcnt_q <= '0;
         scnt_q <= '0;
         icnt_q <= '0;
         if (cfg_win_len == '0)        state_q <= PM_IDLE;
         else if (cfg_start_dly == '0) state_q <= PM_RUN;
         else                          state_q <= PM_DELAY;
      end else begin
         unique case (state_q)
            PM_IDLE: ;
            PM_DELAY: begin
               if (in_valid) begin
                  if ((dcnt_q + DLY_W'(1)) == cfg_start_dly) begin
                     dcnt_q  <= '0;
                     state_q <= PM_RUN;
                  end else begin
                     dcnt_q <= dcnt_q + DLY_W'(1);
                  end
               end
            end
            PM_RUN: begin
               if (in_valid) begin
                  scnt_q <= scnt_q + SCNT_W'(1);
                  icnt_q <= icnt_q + ICNT_W'(1);
                  if (ivl_wrap) begin
                     scnt_q <= '0;
                     icnt_q <= '0;
                  end else if (win_last) begin
                     state_q <= PM_WAIT;
                  end
               end
            end
            PM_WAIT: begin
               if (ivl_tick) begin
                  if (ivl_wrap) begin
                     icnt_q  <= '0;
                     scnt_q  <= '0;
                     state_q <= PM_RUN;
                  end else begin
                     icnt_q <= icnt_q + ICNT_W'(1);
                  end
               end
            end
            default: state_q <= PM_IDLE;
         endcase
      end
   end

   // R4: the skip counter never reaches the programmed delay
   a_r4_delay_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_DELAY) |-> (dcnt_q < cfg_start_dly));

   // R1: inside a window the sample count stays below its length
   a_r1_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == PM_RUN) && (cfg_win_len != '0)) |-> (scnt_q < win_samples));

   // R7: a sync pulse zeroes the window and restart counters
   a_r7_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |=> ((scnt_q == '0) && (icnt_q == '0)));

   // R8: with a zero length no window is ever opened by a sync pulse
   a_r8_zero_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_pulse && (cfg_win_len == '0)) |=> (state_q == PM_IDLE));
endmodule

// File: rtl/pm_result.sv
module pm_result #(
   parameter int NPATH = 2,
   parameter int ACC_W = 52
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        win_last,
   input  logic                        irq_ack,
   input  logic [NPATH-1:0][ACC_W-1:0] sums,
   output logic [NPATH-1:0][ACC_W-1:0] results,
   output logic                        irq
);
   logic accept;

   always_comb accept = win_last && (!irq || irq_ack);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         results <= '0;
      end else begin
         irq <= (irq && !irq_ack) || win_last;
         if (accept) results <= sums;
      end
   end

   // R6: a pending interrupt freezes the visible results
   a_r6_results_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> $stable(results));

   // R6: the flag is sticky until acknowledged
   a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);

   // R1: the flag only rises on a completed window
   a_r1_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !win_last |=> !$rose(irq));
endmodule

// File: rtl/pm_power_meter.sv
module pm_power_meter
   import pm_pkg::*;
#(
   parameter int SMP_W     = 16,
   parameter int LEN_W     = 16,
   parameter int DLY_W     = 8,
   parameter int IVL_W     = 8,
   parameter int GRP_SHIFT = 2,
   parameter int IVL_SHIFT = 10,
   parameter int ACC_W     = 52
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_diversity,
   input  logic [LEN_W-1:0]        cfg_win_len,
   input  logic [DLY_W-1:0]        cfg_start_dly,
   input  logic [IVL_W-1:0]        cfg_restart_ivl,
   input  logic                    sync_pulse,
   input  logic                    in_valid,
   input  logic signed [SMP_W-1:0] sig_i,
   input  logic signed [SMP_W-1:0] sig_q,
   input  logic signed [SMP_W-1:0] div_i,
   input  logic signed [SMP_W-1:0] div_q,
   input  logic                    irq_ack,
   output logic [ACC_W-1:0]        pwr_sig,
   output logic [ACC_W-1:0]        pwr_div,
   output logic                    irq
);
   localparam int PWR_W  = 2*SMP_W + 1;
   localparam int SCNT_W = LEN_W + GRP_SHIFT;

   if (ACC_W < PWR_W + SCNT_W) begin : g_chk_acc
      $error("pm_power_meter: ACC_W cannot hold a full window of peak samples");
   end
   if (SMP_W < 2 || LEN_W < 1 || DLY_W < 1 || IVL_W < 1) begin : g_chk_dims
      $error("pm_power_meter: illegal field width");
   end

   logic                              acc_en;
   logic                              acc_clr;
   logic                              win_last;
   logic signed [PM_NPATH-1:0][SMP_W-1:0] path_i;
   logic signed [PM_NPATH-1:0][SMP_W-1:0] path_q;
   logic [PM_NPATH-1:0][ACC_W-1:0]    sums;
   logic [PM_NPATH-1:0][ACC_W-1:0]    results;

   always_comb begin
      path_i[0] = sig_i;
      path_q[0] = sig_q;
      path_i[1] = div_i;
      path_q[1] = div_q;
   end

   pm_window_ctrl #(
      .LEN_W(LEN_W), .DLY_W(DLY_W), .IVL_W(IVL_W),
      .GRP_SHIFT(GRP_SHIFT), .IVL_SHIFT(IVL_SHIFT)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_win_len(cfg_win_len), .cfg_start_dly(cfg_start_dly),
      .cfg_restart_ivl(cfg_restart_ivl),
      .sync_pulse(sync_pulse), .in_valid(in_valid),
      .acc_en(acc_en), .acc_clr(acc_clr), .win_last(win_last)
   );

   for (genvar p = 0; p < PM_NPATH; p++) begin : g_path
      logic [PWR_W-1:0] mag2;
      logic             path_en;

      // path 0 always runs; later paths only in diversity mode
      if (p == 0) begin : g_main
         always_comb path_en = acc_en;
      end else begin : g_div
         always_comb path_en = acc_en && cfg_diversity;
      end

      pm_square #(.SMP_W(SMP_W), .PWR_W(PWR_W)) u_sq (
         .in_i(path_i[p]), .in_q(path_q[p]), .mag2(mag2)
      );

      pm_accum #(.PWR_W(PWR_W), .ACC_W(ACC_W)) u_acc (
         .clk(clk), .rst_n(rst_n), .en(path_en), .clr(acc_clr),
         .mag2(mag2), .sum(sums[p])
      );
   end

   pm_result #(.NPATH(PM_NPATH), .ACC_W(ACC_W)) u_res (
      .clk(clk), .rst_n(rst_n), .win_last(win_last), .irq_ack(irq_ack),
      .sums(sums), .results(results), .irq(irq)
   );

   always_comb begin
      pwr_sig = results[0];
      pwr_div = results[1];
   end

   // R3: outside diversity mode a completed window reports no diversity power
   a_r3_single_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (win_last && !cfg_diversity && (!irq || irq_ack) && !$past(cfg_diversity))
      |=> (pwr_div == '0));

   // R9: outputs come out of reset cleared
   a_r9_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (!irq && (pwr_sig == '0) && (pwr_div == '0)));
endmodule

// File: tb/sim_pm_power_meter.sv
module sim_pm_power_meter;
   localparam int ACC_W = 52;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_diversity = 1'b0;
   logic [15:0]        cfg_win_len = '0;
   logic [7:0]         cfg_start_dly = '0;
   logic [7:0]         cfg_restart_ivl = '0;
   logic               sync_pulse = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] sig_i = '0, sig_q = '0, div_i = '0, div_q = '0;
   logic               irq_ack = 1'b0;
   logic [ACC_W-1:0]   pwr_sig, pwr_div;
   logic               irq;

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R9";
   int    data_mode = 0;
   bit    done_flag = 0;

   always #5 clk = ~clk;

   pm_power_meter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_diversity(cfg_diversity),
      .cfg_win_len(cfg_win_len), .cfg_start_dly(cfg_start_dly),
      .cfg_restart_ivl(cfg_restart_ivl), .sync_pulse(sync_pulse),
      .in_valid(in_valid), .sig_i(sig_i), .sig_q(sig_q),
      .div_i(div_i), .div_q(div_q), .irq_ack(irq_ack),
      .pwr_sig(pwr_sig), .pwr_div(pwr_div), .irq(irq)
   );

   // behavioural reference: sample index since start, windows by modulo
   longint     m_acc_a, m_acc_b, m_k;
   int         m_skip;
   bit         m_armed, m_irq, m_done;
   logic [ACC_W-1:0] m_pa, m_pb;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc_a = 0; m_acc_b = 0; m_k = 0; m_skip = 0;
         m_armed = 0; m_irq = 0; m_pa = '0; m_pb = '0;
      end else begin
         m_done = 0;
         if (sync_pulse) begin
            m_armed = (cfg_win_len != 0);
            m_skip  = int'(cfg_start_dly);
            m_k = 0; m_acc_a = 0; m_acc_b = 0;
         end else if (in_valid && m_armed) begin
            if (m_skip > 0) m_skip--;
            else begin
               longint per, pos, wl;
               per = longint'(cfg_restart_ivl) * 1024;
               wl  = longint'(cfg_win_len) * 4;
               pos = (per == 0) ? m_k : (m_k % per);
               if (pos == 0) begin m_acc_a = 0; m_acc_b = 0; end
               if (pos < wl) begin
                  m_acc_a += longint'(sig_i)*longint'(sig_i) + longint'(sig_q)*longint'(sig_q);
                  m_acc_b += longint'(div_i)*longint'(div_i) + longint'(div_q)*longint'(div_q);
                  if (pos == wl - 1) m_done = 1;
               end
               m_k++;
            end
         end
         if (m_done && (!m_irq || irq_ack)) begin
            m_pa = ACC_W'(m_acc_a);
            m_pb = cfg_diversity ? ACC_W'(m_acc_b) : '0;
         end
         m_irq = (m_irq && !irq_ack) || m_done;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         chk(cur_req, "irq", ACC_W'(irq), ACC_W'(m_irq));
         chk(cur_req, "pwr_sig", pwr_sig, m_pa);
         chk(cur_req, "pwr_div", pwr_div, m_pb);
      end
   end

   task automatic step(input bit v, input bit s, input bit a);
      @(negedge clk);
      in_valid = v; sync_pulse = s; irq_ack = a;
      if (data_mode == 1) begin
         sig_i = 16'sh8000; sig_q = 16'sh8000; div_i = 16'sh8000; div_q = 16'sh8000;
      end else begin
         sig_i = 16'($urandom); sig_q = 16'($urandom);
         div_i = 16'($urandom); div_q = 16'($urandom);
      end
   endtask

   task automatic run(input int n, input int gap_mod, input int ack_mod);
      for (int k = 0; k < n; k++)
         step((gap_mod == 0) || ($urandom % gap_mod != 0), 1'b0,
              (ack_mod != 0) && ($urandom % ack_mod == 0));
   endtask

   task automatic stop_all();
      cfg_win_len = '0;
      step(1'b1, 1'b1, 1'b1);
      step(1'b0, 1'b0, 1'b0);
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !done_flag) begin
         done_flag = 1;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", wd);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R9";
      chk("R9", "reset irq", ACC_W'(irq), '0);
      chk("R9", "reset pwr_sig", pwr_sig, '0);
      chk("R9", "reset pwr_div", pwr_div, '0);

      // R1/R2/R4: diversity window with delay, valid gaps, sample on sync
      cur_req = "R1"; cfg_diversity = 1; cfg_win_len = 2; cfg_start_dly = 3;
      step(1'b1, 1'b1, 1'b0);
      run(30, 3, 0);
      cur_req = "R4"; step(1'b0, 1'b0, 1'b1);
      step(1'b1, 1'b1, 1'b0);
      run(25, 0, 0);
      step(1'b0, 1'b0, 1'b1);

      // R2: full-scale negative samples
      cur_req = "R2"; data_mode = 1; cfg_win_len = 3; cfg_start_dly = 0;
      step(1'b1, 1'b1, 1'b0);
      run(20, 0, 0);
      data_mode = 0;
      step(1'b0, 1'b0, 1'b1);

      // R3: single-path mode ignores diversity inputs
      stop_all();
      cur_req = "R3"; cfg_diversity = 0; cfg_win_len = 1; cfg_start_dly = 2;
      step(1'b1, 1'b1, 1'b0);
      run(12, 4, 0);

      // R6: completion with irq pending keeps results; then ack on last sample
      cur_req = "R6"; cfg_diversity = 1; cfg_win_len = 2; cfg_start_dly = 0;
      step(1'b1, 1'b1, 1'b0);
      run(12, 0, 0);
      step(1'b1, 1'b1, 1'b1);
      for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 1'b1);
      run(4, 0, 0);
      step(1'b0, 1'b0, 1'b1);

      // R5: periodic restart every 1024 samples
      stop_all();
      cur_req = "R5"; cfg_win_len = 4; cfg_start_dly = 2; cfg_restart_ivl = 1;
      step(1'b1, 1'b1, 1'b0);
      run(2600, 5, 30);
      stop_all();
      cfg_restart_ivl = 0;

      // R7: sync in the middle of a window and of a delay
      cur_req = "R7"; cfg_win_len = 10; cfg_start_dly = 1;
      step(1'b0, 1'b0, 1'b1);
      step(1'b1, 1'b1, 1'b0);
      run(15, 0, 0);
      step(1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b0);
      run(60, 0, 0);
      step(1'b0, 1'b0, 1'b1);

      // R8: zero length never raises irq
      cur_req = "R8"; cfg_win_len = 0;
      step(1'b1, 1'b1, 1'b0);
      run(200, 0, 0);
      @(negedge clk);
      chk("R8", "irq with zero length", ACC_W'(irq), '0);

      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule